// File: doc/BRIEF.md
# Differential Phase Symbol Encoder

This block sits between the transmit serializer and the carrier synthesizer of a differential PSK modem transmitter. Data bits arrive one at a time, qualified by a valid flag, and land in a small ordered buffer. At each symbol strobe, nominally 600 per second, the block takes bits from that buffer and turns them into a carrier phase step. In full-rate mode (1200 bps) a symbol consumes two bits. In half-rate mode (600 bps) a symbol consumes one bit. The step is added, modulo four quadrants, to a running absolute phase.

The running phase comes out as a 2-bit quadrant index and as a phase offset word ready to add to a carrier NCO accumulator. A phase-increment word selects the carrier frequency: the lower carrier (1200 Hz) for the originating side and the upper carrier (2400 Hz) for the answering side. Pulse shaping and conversion to analogue belong to later stages.

Top module: `dpsk_phase_encoder`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe yet, `quadrant` is 0, `phase_offset` is 0, `phase_inc` is the lower-carrier increment and the bit buffer is empty.
- R2: In full-rate mode (`rate_full`=1) a strobe takes the two oldest buffered bits. The first received bit is the left one of the pair. Pair 00 adds 1 quadrant (+90°), 01 adds 0, 10 adds 2 (+180°) and 11 adds 3 (+270°).
- R3: In half-rate mode (`rate_full`=0) a strobe takes the oldest buffered bit. A 0 adds 1 quadrant and a 1 adds 3 quadrants.
- R4: `quadrant` changes only in the cycle after a strobe, wraps modulo 4, and holds its value in every cycle after a cycle without a strobe.
- R5: If the buffer holds fewer bits than the strobe needs, each missing bit counts as 1. An empty buffer therefore gives +3 in either mode.
- R6: A bit presented in the same cycle as a strobe is not used by that symbol. It is appended after the strobe's bits are removed and is used by a later symbol.
- R7: The buffer holds DEPTH bits (default 4), kept in arrival order. A bit offered when no space remains after that cycle's removal is discarded.
- R8: `phase_inc` equals round-down(F·2^NCO_W / SAMPLE_HZ), with F being 1200 Hz when `band_high` was 0 in the previous cycle and 2400 Hz when it was 1 (0x200000 and 0x400000 with the default parameters).
- R9: `phase_offset` equals `quadrant` × 2^(NCO_W-2), that is, quadrant q stands for q·90°.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Serial transmit data bit |
| sym_strobe | input | 1 | Symbol boundary pulse |
| rate_full | input | 1 | 1: two bits per symbol, 0: one bit per symbol |
| band_high | input | 1 | 1: upper carrier, 0: lower carrier |
| quadrant | output | 2 | Absolute carrier phase in 90° units |
| phase_offset | output | NCO_W | Absolute phase scaled to the NCO word |
| phase_inc | output | NCO_W | Carrier NCO increment per sample |

## Verification
Two things can land in the same clock: a symbol strobe that drains the buffer, and a new bit arriving. The bench provokes this on purpose. It strobes on an empty buffer while offering a bit, and it offers a bit to a full buffer while a strobe frees a slot. It judges the result through the phase steps of the following symbols. A bit-ordered reference model in the bench removes bits before appending, and random traffic that mixes both rates and strobes against bursts of bits is compared with that model every cycle.

// File: rtl/dpsk_enc_pkg.sv
package dpsk_enc_pkg;
  typedef logic [1:0] quad_t;
  typedef enum logic {
    RATE_HALF = 1'b0,
    RATE_FULL = 1'b1
  } rate_e;
endpackage

// File: rtl/dpsk_bit_collector.sv
module dpsk_bit_collector #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          push_bit,
  input  logic [1:0]    pop_n,
  output logic [1:0]    head,
  output logic [CW-1:0] level
);
  logic [DEPTH-1:0] mem_q, mem_d;
  logic [CW-1:0]    level_d, level_left;
  logic             accept;

  always_comb begin
    level_left = level - CW'(pop_n);
    accept     = push && (int'(level_left) < DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      if (i + int'(pop_n) < DEPTH) mem_d[i] = mem_q[i + int'(pop_n)];
      else                         mem_d[i] = 1'b0;
      if (accept && (i == int'(level_left))) mem_d[i] = push_bit;
    end
    level_d = accept ? level_left + CW'(1) : level_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      level <= '0;
    end else begin
      mem_q <= mem_d;
      level <= level_d;
    end
  end

  assign head[0] = mem_q[0];
  if (DEPTH > 1) begin : g_two
    assign head[1] = mem_q[1];
  end else begin : g_one
    assign head[1] = 1'b1;
  end

  // R7: occupancy never exceeds the storage
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= DEPTH);
  // R7: a bit offered to a full buffer with no removal is discarded
  a_r7_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && int'(level) == DEPTH && pop_n == 2'd0) |=> (int'(level) == DEPTH));
  // R5: the caller never removes more bits than are held
  a_r5_pop_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(level));
endmodule

// File: rtl/dpsk_phase_map.sv
module dpsk_phase_map
  import dpsk_enc_pkg::*;
(
  input  rate_e      rate,
  input  logic [1:0] avail,
  input  logic [1:0] head,
  output logic [1:0] take,
  output quad_t      delta
);
  logic first_b, second_b;

  always_comb begin
    first_b  = (avail != 2'd0) ? head[0] : 1'b1;
    second_b = (avail == 2'd2) ? head[1] : 1'b1;
    if (rate == RATE_FULL) begin
      take = avail;
      unique case ({first_b, second_b})
        2'b00:   delta = 2'd1;
        2'b01:   delta = 2'd0;
        2'b10:   delta = 2'd2;
        default: delta = 2'd3;
      endcase
    end else begin
      take  = (avail != 2'd0) ? 2'd1 : 2'd0;
      delta = first_b ? 2'd3 : 2'd1;
    end
  end
endmodule

// File: rtl/dpsk_quad_accum.sv
module dpsk_quad_accum
  import dpsk_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_en,
  input  quad_t delta,
  output quad_t quadrant
);
  quad_t quad_d;

  always_comb begin
    quad_d = quadrant;
    if (step_en) quad_d = quadrant + delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) quadrant <= '0;
    else        quadrant <= quad_d;
  end

  // R4: phase holds when no symbol boundary occurred
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(quadrant));
endmodule

// File: rtl/dpsk_carrier_sel.sv
module dpsk_carrier_sel #(
  parameter int NCO_W     = 24,
  parameter int SAMPLE_HZ = 9600,
  parameter int LOW_HZ    = 1200,
  parameter int HIGH_HZ   = 2400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             band_high,
  output logic [NCO_W-1:0] phase_inc
);
  localparam logic [63:0] LOW_FULL  = (64'(LOW_HZ)  << NCO_W) / 64'(SAMPLE_HZ);
  localparam logic [63:0] HIGH_FULL = (64'(HIGH_HZ) << NCO_W) / 64'(SAMPLE_HZ);
  localparam logic [NCO_W-1:0] LOW_INC  = LOW_FULL[NCO_W-1:0];
  localparam logic [NCO_W-1:0] HIGH_INC = HIGH_FULL[NCO_W-1:0];

  logic [NCO_W-1:0] inc_d;

  always_comb inc_d = band_high ? HIGH_INC : LOW_INC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_inc <= LOW_INC;
    else        phase_inc <= inc_d;
  end

  // R8: band request reaches the increment one cycle later
  a_r8_band_high: assert property (@(posedge clk) disable iff (!rst_n)
    band_high |=> (phase_inc == HIGH_INC));
  a_r8_band_low: assert property (@(posedge clk) disable iff (!rst_n)
    !band_high |=> (phase_inc == LOW_INC));
endmodule

// File: rtl/dpsk_phase_encoder.sv
module dpsk_phase_encoder
  import dpsk_enc_pkg::*;
#(
  parameter int DEPTH     = 4,
  parameter int NCO_W     = 24,
  parameter int SAMPLE_HZ = 9600,
  parameter int LOW_HZ    = 1200,
  parameter int HIGH_HZ   = 2400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             sym_strobe,
  input  logic             rate_full,
  input  logic             band_high,
  output logic [1:0]       quadrant,
  output logic [NCO_W-1:0] phase_offset,
  output logic [NCO_W-1:0] phase_inc
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] level;
  logic [1:0]    head, avail, take, pop_n;
  quad_t         delta, quad_q;
  rate_e         rate;

  assign rate  = rate_e'(rate_full);
  assign avail = (int'(level) >= 2) ? 2'd2 : level[1:0];
  assign pop_n = sym_strobe ? take : 2'd0;

  dpsk_bit_collector #(.DEPTH(DEPTH)) u_collect (
    .clk(clk), .rst_n(rst_n), .push(bit_valid), .push_bit(bit_in),
    .pop_n(pop_n), .head(head), .level(level)
  );

  dpsk_phase_map u_map (
    .rate(rate), .avail(avail), .head(head), .take(take), .delta(delta)
  );

  dpsk_quad_accum u_accum (
    .clk(clk), .rst_n(rst_n), .step_en(sym_strobe), .delta(delta),
    .quadrant(quad_q)
  );

  dpsk_carrier_sel #(
    .NCO_W(NCO_W), .SAMPLE_HZ(SAMPLE_HZ), .LOW_HZ(LOW_HZ), .HIGH_HZ(HIGH_HZ)
  ) u_carrier (
    .clk(clk), .rst_n(rst_n), .band_high(band_high), .phase_inc(phase_inc)
  );

  assign quadrant     = quad_q;
  assign phase_offset = {quad_q, {(NCO_W-2){1'b0}}};

  // R3: a held 0 bit in half rate advances by one quadrant
  a_r3_zero_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_strobe && !rate_full && level != '0 && !head[0])
      |=> (quadrant == 2'($past(quadrant) + 2'd1)));
  // R5: an empty buffer at a full-rate strobe acts as the pair 11
  a_r5_empty_full: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_strobe && rate_full && level == '0)
      |=> (quadrant == 2'($past(quadrant) + 2'd3)));
  // R2: held pair 01 gives no phase step
  a_r2_pair01: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_strobe && rate_full && int'(level) >= 2 && !head[0] && head[1])
      |=> $stable(quadrant));
endmodule

// File: tb/dpsk_phase_encoder_test.sv
module dpsk_phase_encoder_test;
  localparam int DEPTH = 4;
  localparam int NCO_W = 24;
  localparam logic [NCO_W-1:0] EXP_LOW  = 24'h200000;
  localparam logic [NCO_W-1:0] EXP_HIGH = 24'h400000;

  logic clk = 1'b0;
  logic rst_n, bit_valid, bit_in, sym_strobe, rate_full, band_high;
  logic [1:0] quadrant;
  logic [NCO_W-1:0] phase_offset, phase_inc;

  int checks = 0, failures = 0;
  bit done = 0;
  bit mq[$];
  logic [1:0] exp_q;
  logic [NCO_W-1:0] exp_inc;

  always #4 clk = ~clk;

  dpsk_phase_encoder uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .sym_strobe(sym_strobe), .rate_full(rate_full), .band_high(band_high),
    .quadrant(quadrant), .phase_offset(phase_offset), .phase_inc(phase_inc)
  );

  function automatic logic [1:0] pair_step(bit a, bit b);
    if (!a && !b) return 2'd1;
    if (!a &&  b) return 2'd0;
    if ( a && !b) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " quadrant"}, 64'(quadrant), 64'(exp_q));
    chk("R9 phase_offset", 64'(phase_offset), 64'({exp_q, 22'd0}));
    chk("R8 phase_inc", 64'(phase_inc), 64'(exp_inc));
  endtask

  task automatic cyc(bit bv, bit b, bit st, bit rf, bit bh, string tag);
    @(negedge clk);
    bit_valid = bv; bit_in = b; sym_strobe = st; rate_full = rf; band_high = bh;
    @(posedge clk);
    if (st) begin
      bit a1 = 1'b1, a2 = 1'b1;
      if (mq.size() > 0) a1 = mq.pop_front();
      if (rf) begin
        if (mq.size() > 0) a2 = mq.pop_front();
        exp_q = exp_q + pair_step(a1, a2);
      end else begin
        exp_q = exp_q + (a1 ? 2'd3 : 2'd1);
      end
    end
    if (bv && mq.size() < DEPTH) mq.push_back(b);
    exp_inc = bh ? EXP_HIGH : EXP_LOW;
    #1;
    check_all(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_valid = 0; bit_in = 0; sym_strobe = 0; rate_full = 0; band_high = 0;
    exp_q = 2'd0; exp_inc = EXP_LOW;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    idle(2, "R1 after release");

    // R2: each pair, first bit is left-hand
    for (int p = 0; p < 4; p++) begin
      cyc(1, p[1], 0, 1, 0, "R2");
      cyc(1, p[0], 0, 1, 0, "R2");
      cyc(0, 0, 1, 1, 0, "R2 pair step");
      idle(1, "R4 hold");
    end
    // R3: single bits
    cyc(1, 0, 0, 0, 0, "R3"); cyc(0, 0, 1, 0, 0, "R3 zero bit");
    cyc(1, 1, 0, 0, 0, "R3"); cyc(0, 0, 1, 0, 0, "R3 one bit");
    // R5: empty buffer in both modes, and half-filled pair
    cyc(0, 0, 1, 0, 0, "R5 empty half");
    cyc(0, 0, 1, 1, 0, "R5 empty full");
    cyc(1, 0, 0, 1, 0, "R5");
    cyc(0, 0, 1, 1, 0, "R5 lone bit pair");
    // R6: bit with strobe on empty buffer is kept for next symbol
    cyc(1, 0, 1, 0, 0, "R6 same cycle");
    cyc(0, 0, 1, 0, 0, "R6 deferred bit");
    // R7: overfill, then drain; full buffer with removal accepts a bit
    for (int i = 0; i < 6; i++) cyc(1, i[0], 0, 0, 0, "R7 fill");
    cyc(1, 0, 1, 0, 0, "R7 full with removal");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 0, "R7 drain");
    // R8: band toggling
    cyc(0, 0, 0, 0, 1, "R8 high");
    cyc(0, 0, 0, 0, 0, "R8 low");
    // R4: wrap through many strobes
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1, 0, "R4 wrap");

    // random mix
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      cyc(r < 55, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
          (i / 300) % 2 == 0, $urandom_range(0, 7) == 0 ? ~band_high : band_high,
          "R2 R3 R6 random");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule